// File: doc/BRIEF.md
# Multicart Outer Register Write Decoder

This block watches the CPU write bus of a multicart bank controller and keeps the outer banking state. That state is four outer registers, four extra bank registers and a two-bit character latch used in simple mode. Writes in the low window (0x5000 to 0x5FFF) load the outer registers. A strap chooses which address bit must be set for such a write to count.

Writes in the high window (0x8000 to 0xFFFF) are handled in one of three ways. They can be captured by the simple-mode latch, or redirected into the extra bank registers. Otherwise they are forwarded to the inner bank-switching controller as either a command/data write or an IRQ write.

The block raises a one-cycle remap pulse whenever the bank mapping must be recomputed. Two board-variant inputs select board-specific behaviour: one clears the mode bits when extra banking is enabled, and one swaps two command values on boards with character RAM. All state changes on the clock edge that samples the write strobe.

Top module: `mcart_outer_regs`

## Requirements
- R1: After reset the outer registers read 0x00, the extra registers read 0xFF, the latch reads 0, and remap, command-forward and IRQ-forward are all low. The selector register is 0 during reset and follows the strap one cycle later.
- R2: A write in 0x5000..0x5FFF loads outer register (address AND 3) only when address bit (selector + 4) is 1; otherwise no outer register changes. Outer register k appears on byte k of `oreg_o`.
- R3: An accepted low-window write raises `remap_o` for exactly the one cycle after the sampling edge. This happens when the index is 1 or 2, or when outer register 0 after the write has upper nibble 0x2. Other accepted low writes and rejected low writes leave it low.
- R4: With `variant_i` high, every low-window write, accepted or not, clears bits 2:0 of outer register 0 when bit 1 of outer register 3 (after the write) is set. With `variant_i` low, no clearing happens.
- R5: While bit 6 of outer register 0 is set, a high-window write sets the latch to 0 if bits 5:4 of register 0 are nonzero, and otherwise to data bits 1:0. The write is not forwarded and raises no remap.
- R6: Outside latch mode, a write to exactly 0x8001 with outer register 3 bit 1 and `inner_cmd_i` bit 3 both set is redirected. It stores the data in extra register 4 + `inner_cmd_i[1:0]` (byte `inner_cmd_i[1:0]` of `ext_o`), raises remap and is not forwarded.
- R7: Any other high-window write below 0xC000 pulses `fwd_cmd_we_o` for one cycle and presents its address and data on `fwd_addr_o` and `fwd_data_o`.
- R8: With `chr_ram_i` high, a forwarded write to exactly 0x8000 has data 0x46 and 0x47 exchanged. Every other address or value is forwarded unchanged.
- R9: Other high-window writes at 0xC000 and above pulse `fwd_irq_we_o` for one cycle, and `fwd_cmd_we_o` stays low.
- R10: Writes outside both windows change no register and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr_i | input | 16 | CPU write address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | CPU write strobe, sampled on the rising edge |
| strap_sel_i | input | 3 | Strap choosing the low-window enable address bit (bit = value + 4) |
| variant_i | input | 1 | Board variant that clears mode bits when extra banking is on |
| chr_ram_i | input | 1 | Board has character RAM (enables the 0x46/0x47 exchange) |
| inner_cmd_i | input | 8 | Current command register of the inner controller |
| oreg_o | output | 32 | Outer registers 0..3, register k in byte k |
| ext_o | output | 32 | Extra registers 4..7, register 4+k in byte k |
| latch_o | output | 2 | Simple-mode character latch |
| remap_o | output | 1 | One-cycle request to recompute the mapping |
| fwd_cmd_we_o | output | 1 | One-cycle command/data write to the inner controller |
| fwd_irq_we_o | output | 1 | One-cycle IRQ-range write to the inner controller |
| fwd_addr_o | output | 16 | Address of the last forwarded write |
| fwd_data_o | output | 8 | Data of the last forwarded write, after any exchange |

## Verification
The bench builds the block with its default widths: 16-bit address, 8-bit data, four outer and four extra registers, and a three-bit selector. This lets the strap reach enable bits 4 through 11, so the test can show a write accepted under one strap value and rejected under another. The 8-bit command input lets every extra-register slot and the bit-3 gate be driven directly. The default data width covers the full 0x46/0x47 exchange, along with its neighbours, which must pass through unchanged.

// File: rtl/mcart_pkg.sv
package mcart_pkg;
    localparam int AW      = 16;
    localparam int DW      = 8;
    localparam int NREG    = 4;
    localparam int NEXT    = 4;
    localparam int SEL_W   = 3;
    localparam int LATCH_W = 2;
    localparam int IDX_W   = $clog2(NREG);
    localparam int EIDX_W  = $clog2(NEXT);
    localparam int SEL_BASE = 4;

    localparam logic [AW-1:0] EXT_PORT_ADDR = 16'h8001;
    localparam logic [AW-1:0] SWAP_ADDR     = 16'h8000;
    localparam logic [AW-1:0] IRQ_BASE      = 16'hC000;
    localparam logic [3:0]    LO_PAGE       = 4'h5;
    localparam logic [DW-1:0] SWAP_A        = 8'h46;
    localparam logic [DW-1:0] SWAP_B        = 8'h47;

    typedef logic [NREG-1:0][DW-1:0] oreg_t;
    typedef logic [NEXT-1:0][DW-1:0] ext_t;

    typedef struct packed {
        oreg_t              oreg;
        ext_t               ext;
        logic [LATCH_W-1:0] latch;
        logic [SEL_W-1:0]   sel;
        logic               remap;
        logic               fwd_cmd;
        logic               fwd_irq;
        logic [AW-1:0]      fwd_addr;
        logic [DW-1:0]      fwd_data;
    } state_t;

    function automatic logic in_lo(input logic [AW-1:0] a);
        return a[AW-1:AW-4] == LO_PAGE;
    endfunction

    function automatic logic in_hi(input logic [AW-1:0] a);
        return a[AW-1];
    endfunction
endpackage

// File: rtl/mcart_lo_dec.sv
module mcart_lo_dec
    import mcart_pkg::*;
(
    input  oreg_t            cur_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    data_i,
    input  logic             we_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             variant_i,
    output oreg_t            nxt_o,
    output logic             remap_o
);
    logic             lo_hit;
    logic             gate_bit;
    logic [IDX_W-1:0] idx;
    oreg_t            tmp;

    assign lo_hit   = we_i && in_lo(addr_i);
    assign gate_bit = addr_i[SEL_BASE + int'(sel_i)];
    assign idx      = addr_i[IDX_W-1:0];

    always_comb begin
        tmp     = cur_i;
        remap_o = 1'b0;
        if (lo_hit) begin
            if (gate_bit) begin
                tmp[idx] = data_i;
                remap_o  = (idx == IDX_W'(1)) || (idx == IDX_W'(2)) ||
                           (tmp[0][7:4] == 4'h2);
            end
            if (variant_i && tmp[3][1]) begin
                tmp[0][2:0] = 3'b000;
            end
        end
        nxt_o = tmp;
    end
endmodule

// File: rtl/mcart_hi_dec.sv
module mcart_hi_dec
    import mcart_pkg::*;
(
    input  oreg_t               oreg_i,
    input  ext_t                ext_i,
    input  logic [LATCH_W-1:0]  latch_i,
    input  logic [AW-1:0]       addr_i,
    input  logic [DW-1:0]       data_i,
    input  logic                we_i,
    input  logic [DW-1:0]       inner_cmd_i,
    input  logic                chr_ram_i,
    output ext_t                ext_o,
    output logic [LATCH_W-1:0]  latch_o,
    output logic                remap_o,
    output logic                fwd_cmd_o,
    output logic                fwd_irq_o,
    output logic [DW-1:0]       fwd_data_o
);
    logic hi_hit;
    logic latch_mode;
    logic redirect;
    logic [EIDX_W-1:0] eidx;

    assign hi_hit     = we_i && in_hi(addr_i);
    assign latch_mode = oreg_i[0][6];
    assign redirect   = (addr_i == EXT_PORT_ADDR) && oreg_i[3][1] && inner_cmd_i[3];
    assign eidx       = inner_cmd_i[EIDX_W-1:0];

    always_comb begin
        ext_o      = ext_i;
        latch_o    = latch_i;
        remap_o    = 1'b0;
        fwd_cmd_o  = 1'b0;
        fwd_irq_o  = 1'b0;
        fwd_data_o = data_i;
        if (hi_hit) begin
            if (latch_mode) begin
                latch_o = (oreg_i[0][5:4] != 2'b00) ? '0 : data_i[LATCH_W-1:0];
            end else if (redirect) begin
                ext_o[eidx] = data_i;
                remap_o     = 1'b1;
            end else if (addr_i < IRQ_BASE) begin
                fwd_cmd_o = 1'b1;
                if (chr_ram_i && addr_i == SWAP_ADDR) begin
                    if (data_i == SWAP_A)      fwd_data_o = SWAP_B;
                    else if (data_i == SWAP_B) fwd_data_o = SWAP_A;
                end
            end else begin
                fwd_irq_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mcart_outer_regs.sv
module mcart_outer_regs
    import mcart_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       cpu_addr_i,
    input  logic [DW-1:0]       cpu_data_i,
    input  logic                cpu_we_i,
    input  logic [SEL_W-1:0]    strap_sel_i,
    input  logic                variant_i,
    input  logic                chr_ram_i,
    input  logic [DW-1:0]       inner_cmd_i,
    output logic [NREG*DW-1:0]  oreg_o,
    output logic [NEXT*DW-1:0]  ext_o,
    output logic [LATCH_W-1:0]  latch_o,
    output logic                remap_o,
    output logic                fwd_cmd_we_o,
    output logic                fwd_irq_we_o,
    output logic [AW-1:0]       fwd_addr_o,
    output logic [DW-1:0]       fwd_data_o
);
    state_t st_d, st_q;

    oreg_t              lo_nxt;
    logic               lo_remap;
    ext_t               hi_ext;
    logic [LATCH_W-1:0] hi_latch;
    logic               hi_remap, hi_cmd, hi_irq;
    logic [DW-1:0]      hi_data;

    mcart_lo_dec u_lo (
        .cur_i     (st_q.oreg),
        .addr_i    (cpu_addr_i),
        .data_i    (cpu_data_i),
        .we_i      (cpu_we_i),
        .sel_i     (st_q.sel),
        .variant_i (variant_i),
        .nxt_o     (lo_nxt),
        .remap_o   (lo_remap)
    );

    mcart_hi_dec u_hi (
        .oreg_i      (st_q.oreg),
        .ext_i       (st_q.ext),
        .latch_i     (st_q.latch),
        .addr_i      (cpu_addr_i),
        .data_i      (cpu_data_i),
        .we_i        (cpu_we_i),
        .inner_cmd_i (inner_cmd_i),
        .chr_ram_i   (chr_ram_i),
        .ext_o       (hi_ext),
        .latch_o     (hi_latch),
        .remap_o     (hi_remap),
        .fwd_cmd_o   (hi_cmd),
        .fwd_irq_o   (hi_irq),
        .fwd_data_o  (hi_data)
    );

    always_comb begin
        st_d          = st_q;
        st_d.sel      = strap_sel_i;
        st_d.oreg     = lo_nxt;
        st_d.ext      = hi_ext;
        st_d.latch    = hi_latch;
        st_d.remap    = lo_remap | hi_remap;
        st_d.fwd_cmd  = hi_cmd;
        st_d.fwd_irq  = hi_irq;
        if (hi_cmd || hi_irq) begin
            st_d.fwd_addr = cpu_addr_i;
            st_d.fwd_data = hi_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.ext      <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign oreg_o       = st_q.oreg;
    assign ext_o        = st_q.ext;
    assign latch_o      = st_q.latch;
    assign remap_o      = st_q.remap;
    assign fwd_cmd_we_o = st_q.fwd_cmd;
    assign fwd_irq_we_o = st_q.fwd_irq;
    assign fwd_addr_o   = st_q.fwd_addr;
    assign fwd_data_o   = st_q.fwd_data;

    // Latch mode swallows high-window writes
    assert_latch_no_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we_i && cpu_addr_i[AW-1] && oreg_o[6])
        |=> (!fwd_cmd_we_o && !fwd_irq_we_o && !remap_o));

    assert_latch_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we_i && cpu_addr_i[AW-1] && oreg_o[6] && (oreg_o[5:4] != 2'b00))
        |=> (latch_o == '0));

    assert_ext_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we_i && cpu_addr_i == EXT_PORT_ADDR && !oreg_o[6] &&
         oreg_o[3*DW+1] && inner_cmd_i[3])
        |=> (remap_o && !fwd_cmd_we_o));

    assert_irq_fwd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we_i && cpu_addr_i >= IRQ_BASE && !oreg_o[6])
        |=> (fwd_irq_we_o && !fwd_cmd_we_o));

    assert_outside_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we_i && !in_lo(cpu_addr_i) && !in_hi(cpu_addr_i))
        |=> ($stable(oreg_o) && $stable(ext_o) && $stable(latch_o) &&
             !remap_o && !fwd_cmd_we_o && !fwd_irq_we_o));

    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_cmd_we_o && fwd_irq_we_o));
endmodule

// File: tb/mcart_outer_regs_tb.sv
module mcart_outer_regs_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  data = '0;
    logic        we = 1'b0;
    logic [2:0]  strap = '0;
    logic        variant = 1'b0;
    logic        chr_ram = 1'b0;
    logic [7:0]  icmd = '0;
    logic [31:0] oreg, ext;
    logic [1:0]  latch;
    logic        remap, fcmd, firq;
    logic [15:0] faddr;
    logic [7:0]  fdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcart_outer_regs u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr_i(addr), .cpu_data_i(data),
        .cpu_we_i(we), .strap_sel_i(strap), .variant_i(variant),
        .chr_ram_i(chr_ram), .inner_cmd_i(icmd), .oreg_o(oreg), .ext_o(ext),
        .latch_o(latch), .remap_o(remap), .fwd_cmd_we_o(fcmd),
        .fwd_irq_we_o(firq), .fwd_addr_o(faddr), .fwd_data_o(fdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; data = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 oreg", oreg, 32'h0);
        chk("R1 ext", ext, 32'hFFFF_FFFF);
        chk("R1 latch", {30'd0, latch}, 32'd0);
        chk("R1 strobes", {29'd0, remap, fcmd, firq}, 32'd0);
    endtask

    task automatic t_gate;
        strap = 3'd0; idle(2);
        wr(16'h5010, 8'h12);
        chk("R2 reg0 via bit4", {24'd0, oreg[7:0]}, 32'h12);
        chk("R3 reg0 no remap", {31'd0, remap}, 32'd0);
        wr(16'h5001, 8'h34);
        chk("R2 rejected bit4 clear", {24'd0, oreg[15:8]}, 32'h00);
        chk("R3 rejected no remap", {31'd0, remap}, 32'd0);
        strap = 3'd2; idle(2);
        wr(16'h5041, 8'h55);
        chk("R2 reg1 via bit6", {24'd0, oreg[15:8]}, 32'h55);
        chk("R3 reg1 remap", {31'd0, remap}, 32'd1);
        idle(1);
        chk("R3 remap one cycle", {31'd0, remap}, 32'd0);
        wr(16'h5011, 8'h66);
        chk("R2 rejected strap2", {24'd0, oreg[15:8]}, 32'h55);
        strap = 3'd0; idle(2);
    endtask

    task automatic t_remap;
        wr(16'h5010, 8'h24);
        chk("R3 nibble2 remap", {31'd0, remap}, 32'd1);
        wr(16'h5013, 8'h00);
        chk("R3 reg3 with nibble2", {31'd0, remap}, 32'd1);
        wr(16'h5010, 8'h00);
        chk("R3 reg0 plain", {31'd0, remap}, 32'd0);
        wr(16'h5012, 8'h07);
        chk("R3 reg2 remap", {31'd0, remap}, 32'd1);
        chk("R2 reg2 value", {24'd0, oreg[23:16]}, 32'h07);
        wr(16'h5013, 8'h01);
        chk("R3 reg3 plain", {31'd0, remap}, 32'd0);
    endtask

    task automatic t_variant;
        variant = 1'b0;
        wr(16'h5010, 8'h05);
        wr(16'h5013, 8'h02);
        chk("R4 no clear off variant", {24'd0, oreg[7:0]}, 32'h05);
        variant = 1'b1;
        wr(16'h5010, 8'h0D);
        chk("R4 clear after accepted", {24'd0, oreg[7:0]}, 32'h08);
        wr(16'h5010, 8'h00);
        wr(16'h5013, 8'h00);
        variant = 1'b0;
        wr(16'h5010, 8'h0F);
        variant = 1'b1;
        wr(16'h5013, 8'h02);
        chk("R4 clear on reg3 write", {24'd0, oreg[7:0]}, 32'h08);
        wr(16'h5010, 8'h0F);
        variant = 1'b0;
        wr(16'h5013, 8'h00);
        chk("R4 no clear after off", {24'd0, oreg[7:0]}, 32'h08);
        variant = 1'b1;
        wr(16'h5010, 8'h0F);
        wr(16'h5013, 8'h02);
        chk("R4 clear again", {24'd0, oreg[7:0]}, 32'h08);
        wr(16'h5000, 8'hAA); // rejected, reg0 not touched by data
        chk("R4 rejected keeps reg0", {24'd0, oreg[7:0]}, 32'h08);
        variant = 1'b0;
        wr(16'h5013, 8'h00);
        wr(16'h5010, 8'h00);
    endtask

    task automatic t_latch;
        wr(16'h5010, 8'h40);
        wr(16'h8000, 8'h03);
        chk("R5 capture", {30'd0, latch}, 32'd3);
        chk("R5 no forward", {29'd0, remap, fcmd, firq}, 32'd0);
        wr(16'h5010, 8'h50);
        wr(16'hC000, 8'h02);
        chk("R5 zero when 5:4 set", {30'd0, latch}, 32'd0);
        chk("R5 no irq fwd", {31'd0, firq}, 32'd0);
        wr(16'h5010, 8'h40);
        wr(16'hE000, 8'h02);
        chk("R5 capture 2", {30'd0, latch}, 32'd2);
        wr(16'h5010, 8'h00);
    endtask

    task automatic t_ext;
        wr(16'h5013, 8'h02);
        icmd = 8'h0A;
        wr(16'h8001, 8'h9C);
        chk("R6 ext6", ext, 32'hFF9C_FFFF);
        chk("R6 remap", {31'd0, remap}, 32'd1);
        chk("R6 no fwd", {31'd0, fcmd}, 32'd0);
        icmd = 8'h02;
        wr(16'h8001, 8'h11);
        chk("R6 cmd bit3 clear fwd", {31'd0, fcmd}, 32'd1);
        chk("R6 ext unchanged", ext, 32'hFF9C_FFFF);
        icmd = 8'h0B;
        wr(16'h8003, 8'h22);
        chk("R6 other addr fwd", {31'd0, fcmd}, 32'd1);
        wr(16'h8001, 8'h33);
        chk("R6 ext7", ext, 32'h339C_FFFF);
        wr(16'h5013, 8'h00);
        icmd = 8'h08;
        wr(16'h8001, 8'h44);
        chk("R6 reg3 clear fwd", {31'd0, fcmd}, 32'd1);
        chk("R6 ext4 untouched", ext, 32'h339C_FFFF);
        icmd = 8'h00;
    endtask

    task automatic t_fwd;
        chr_ram = 1'b0;
        wr(16'h8000, 8'h46);
        chk("R7 cmd strobe", {31'd0, fcmd}, 32'd1);
        chk("R7 addr", {16'd0, faddr}, 32'h8000);
        chk("R8 no swap", {24'd0, fdata}, 32'h46);
        idle(1);
        chk("R7 strobe one cycle", {31'd0, fcmd}, 32'd0);
        chr_ram = 1'b1;
        wr(16'h8000, 8'h46);
        chk("R8 46 to 47", {24'd0, fdata}, 32'h47);
        wr(16'h8000, 8'h47);
        chk("R8 47 to 46", {24'd0, fdata}, 32'h46);
        wr(16'h8001, 8'h46);
        chk("R8 other addr kept", {24'd0, fdata}, 32'h46);
        wr(16'h8000, 8'h45);
        chk("R8 other value kept", {24'd0, fdata}, 32'h45);
        chr_ram = 1'b0;
        wr(16'hBFFF, 8'h5A);
        chk("R7 top of cmd range", {15'd0, fcmd, faddr}, 32'h1_BFFF);
        wr(16'hC000, 8'h77);
        chk("R9 irq strobe", {30'd0, fcmd, firq}, 32'd1);
        chk("R9 irq data", {24'd0, fdata}, 32'h77);
        wr(16'hFFFF, 8'h01);
        chk("R9 irq top", {15'd0, firq, faddr}, 32'h1_FFFF);
    endtask

    task automatic t_ignore;
        logic [31:0] o0, e0;
        o0 = oreg; e0 = ext;
        wr(16'h4FFF, 8'hEE);
        chk("R10 4FFF regs", oreg, o0);
        chk("R10 4FFF strobes", {29'd0, remap, fcmd, firq}, 32'd0);
        wr(16'h6013, 8'hEE);
        chk("R10 6013 regs", oreg, o0);
        chk("R10 6013 ext", ext, e0);
        chk("R10 6013 strobes", {29'd0, remap, fcmd, firq}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        strap = 3'd5;
        idle(4);
        rst_n = 1'b1;
        t_reset();
        idle(1);
        t_gate();
        t_remap();
        t_variant();
        t_latch();
        t_ext();
        t_fwd();
        t_ignore();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule